// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits beside a level-one cache and hides part of the cost of sequential misses. It holds a small set of stream buffers. Each one is a short FIFO of consecutive cache-line addresses with their fill data. Every access is compared against the oldest entry (the head) of every buffer in the same cycle as the cache lookup. A head that matches and holds its data returns the line at once, with no memory access. A head that matches but is still waiting for its fill stalls the requester until the data arrives.

When the cache misses and no buffer head matches, the least recently used buffer is taken over. Its old contents are discarded, and it is loaded with the missed line and the lines that follow it. Each head hit removes the head entry and reuses the freed slot for the line just past the tail, so a buffer keeps running ahead of a sequential stream. Several buffers follow independent streams.

All buffers share one memory request port. The port issues at most one line request per cycle and picks between buffers round robin. A response carries the tag of its request, which names the buffer and the slot.

Each slot is a small state machine with these states:
- SLOT_IDLE: the slot has held nothing since reset.
- SLOT_WANT: a line is assigned and its request has not yet been granted.
- SLOT_PEND: the request has been granted and the fill is outstanding.
- SLOT_ORPHAN: the line was reassigned while a fill was still outstanding, and that stale fill must be discarded.
- SLOT_READY: the data is present.

The slot moves between states as follows:
- Reallocation: any slot goes to WANT. It goes to ORPHAN instead if a fill for it is still outstanding and does not arrive in that same cycle.
- Grant: WANT goes to PEND.
- Fill: PEND goes to READY, and ORPHAN goes to WANT.
- Head pop: READY goes to WANT, with the new line address.

Top module: `stream_prefetch`

## Requirements
- R1: An access with `acc_valid`=1 and `l1_miss`=1 that matches no buffer head reallocates one buffer. That buffer then requests the lines `acc_line`, `acc_line`+1, `acc_line`+2 and `acc_line`+3 (DEPTH=4) on `mem_req_line`, in ascending order.
- R2: A head match whose data has arrived raises `sb_hit` in the same cycle as the access. `sb_data` then equals the fill data returned for that line, and `sb_stall` stays 0. With `acc_valid`=0, both `sb_hit` and `sb_stall` are 0.
- R3: A head hit removes the head entry. The freed slot then requests the line DEPTH above the popped line, so after a hit on line L the next request is L+4.
- R4: A head match whose fill has not yet arrived raises `sb_stall` and keeps `sb_hit` at 0. Once the fill returns, the same access produces `sb_hit`. The two flags are never 1 together.
- R5: An access with `l1_miss`=0 that matches no head leaves every buffer unchanged.
- R6: Reallocation picks the least recently used buffer. Both a reallocation and a head hit count as a use. With two buffers, a stream that keeps hitting survives a miss on a new stream.
- R7: A fill that returns for a slot that was reallocated after its request is discarded. The buffer later returns the correct data for the lines newly assigned to it.
- R8: At most one request is issued per cycle. When several buffers have lines waiting, grants rotate between them round robin. The buffer number is the top bit of `mem_req_tag`, and the slot number is the two low bits.
- R9: A request shown with `mem_req_ready`=0 stays valid, with the same line, until it is accepted.
- R10: After reset, `sb_hit`, `sb_stall` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | LINE_W (16) | Line address of the access |
| l1_miss | input | 1 | The cache missed on this access |
| sb_hit | output | 1 | The line is supplied from a buffer head |
| sb_stall | output | 1 | A head matches but its fill is outstanding |
| sb_data | output | DATA_W (32) | Line data for a hit |
| mem_req_valid | output | 1 | A line request is offered |
| mem_req_ready | input | 1 | Memory accepts the offered request |
| mem_req_line | output | LINE_W (16) | Requested line address |
| mem_req_tag | output | TAG_W (3) | Buffer and slot of the request |
| mem_rsp_valid | input | 1 | A fill response is present |
| mem_rsp_tag | input | TAG_W (3) | Tag of the request being answered |
| mem_rsp_data | input | DATA_W (32) | Fill data |

## Verification
Three things can land on the same slot in one cycle: a buffer reallocation, the grant of one of that buffer's requests, and the arrival of an older fill for it. The bench provokes this with three misses on new streams in consecutive cycles. The third miss takes back the first buffer while that buffer's first fills are still in flight. The result is judged by reading the new lines through head hits and comparing each against the memory model's data for that line address. The bench also holds the request port stalled while two buffers fill up with waiting lines. It then checks that the held request keeps its line, and that the granted tags alternate between buffers once the port opens.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [2:0] {
        SLOT_IDLE,
        SLOT_WANT,
        SLOT_PEND,
        SLOT_ORPHAN,
        SLOT_READY
    } slot_st_e;
endpackage

// File: rtl/sbp_arb.sv
module sbp_arb #(
    parameter int N = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N-1:0]                       req,
    input  logic                               adv,
    output logic                               any,
    output logic [$clog2(N > 1 ? N : 2)-1:0]   pick
);
    localparam int W = $clog2(N > 1 ? N : 2);

    logic [W-1:0] rr;

    // search from the rotating pointer; the lowest offset wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[(int'(rr) + k) % N]) begin
                any  = 1'b1;
                pick = W'((int'(rr) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr <= '0;
        end else if (adv) begin
            rr <= W'((int'(pick) + 1) % N);
        end
    end
endmodule

// File: rtl/sbp_lru.sv
module sbp_lru #(
    parameter int N = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               touch,
    input  logic [$clog2(N > 1 ? N : 2)-1:0]   touch_id,
    output logic [$clog2(N > 1 ? N : 2)-1:0]   victim
);
    localparam int W = $clog2(N > 1 ? N : 2);

    logic [W-1:0] age [N];

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (age[i] == W'(N - 1)) victim = W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= W'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (W'(i) == touch_id)          age[i] <= '0;
                else if (age[i] < age[touch_id]) age[i] <= age[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbp_way.sv
module sbp_way
    import sbp_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic [LINE_W-1:0]          acc_line,
    input  logic                       alloc,
    input  logic                       pop,
    input  logic                       grant,
    input  logic                       rsp_valid,
    input  logic [$clog2(DEPTH)-1:0]   rsp_slot,
    input  logic [DATA_W-1:0]          rsp_data,
    output logic                       head_match,
    output logic                       head_ready,
    output logic [DATA_W-1:0]          head_data,
    output logic                       req_valid,
    output logic [LINE_W-1:0]          req_line,
    output logic [$clog2(DEPTH)-1:0]   req_slot
);
    localparam int SLOT_W = $clog2(DEPTH);

    slot_st_e          st    [DEPTH];
    slot_st_e          st_n  [DEPTH];
    logic [LINE_W-1:0] ln    [DEPTH];
    logic [LINE_W-1:0] ln_n  [DEPTH];
    logic [DATA_W-1:0] dt    [DEPTH];
    logic [DATA_W-1:0] dt_n  [DEPTH];
    logic [SLOT_W-1:0] hd;

    assign head_match = acc_valid && (st[hd] != SLOT_IDLE) && (ln[hd] == acc_line);
    assign head_ready = (st[hd] == SLOT_READY);
    assign head_data  = dt[hd];

    // oldest waiting slot, counted from the head
    always_comb begin
        req_valid = 1'b0;
        req_slot  = hd;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (st[hd + SLOT_W'(k)] == SLOT_WANT) begin
                req_valid = 1'b1;
                req_slot  = hd + SLOT_W'(k);
            end
        end
        req_line = ln[req_slot];
    end

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            st_n[s] = st[s];
            ln_n[s] = ln[s];
            dt_n[s] = dt[s];
            if (alloc) begin
                ln_n[s] = acc_line + LINE_W'(s);
                if (((st[s] == SLOT_PEND) || (st[s] == SLOT_ORPHAN) ||
                     (grant && req_slot == SLOT_W'(s))) &&
                    !(rsp_valid && rsp_slot == SLOT_W'(s)))
                    st_n[s] = SLOT_ORPHAN;
                else
                    st_n[s] = SLOT_WANT;
            end else if (pop && hd == SLOT_W'(s)) begin
                ln_n[s] = ln[s] + LINE_W'(DEPTH);
                st_n[s] = SLOT_WANT;
            end else begin
                unique case (st[s])
                    SLOT_WANT:   if (grant && req_slot == SLOT_W'(s)) st_n[s] = SLOT_PEND;
                    SLOT_PEND:   if (rsp_valid && rsp_slot == SLOT_W'(s)) begin
                                     st_n[s] = SLOT_READY;
                                     dt_n[s] = rsp_data;
                                 end
                    SLOT_ORPHAN: if (rsp_valid && rsp_slot == SLOT_W'(s)) st_n[s] = SLOT_WANT;
                    default:     ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                st[s] <= SLOT_IDLE;
                ln[s] <= '0;
                dt[s] <= '0;
            end
        end else begin
            if (alloc)    hd <= '0;
            else if (pop) hd <= hd + 1'b1;
            for (int s = 0; s < DEPTH; s++) begin
                st[s] <= st_n[s];
                ln[s] <= ln_n[s];
                dt[s] <= dt_n[s];
            end
        end
    end

    // R3
    pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (head_ready && head_match));
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
    parameter int NUM_BUF = 2,
    parameter int DEPTH   = 4,
    parameter int LINE_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic                                                    clk,
    input  logic                                                    rst_n,
    input  logic                                                    acc_valid,
    input  logic [LINE_W-1:0]                                       acc_line,
    input  logic                                                    l1_miss,
    output logic                                                    sb_hit,
    output logic                                                    sb_stall,
    output logic [DATA_W-1:0]                                       sb_data,
    output logic                                                    mem_req_valid,
    input  logic                                                    mem_req_ready,
    output logic [LINE_W-1:0]                                       mem_req_line,
    output logic [$clog2(NUM_BUF > 1 ? NUM_BUF : 2)+$clog2(DEPTH)-1:0] mem_req_tag,
    input  logic                                                    mem_rsp_valid,
    input  logic [$clog2(NUM_BUF > 1 ? NUM_BUF : 2)+$clog2(DEPTH)-1:0] mem_rsp_tag,
    input  logic [DATA_W-1:0]                                       mem_rsp_data
);
    localparam int BUF_W  = $clog2(NUM_BUF > 1 ? NUM_BUF : 2);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int TAG_W  = BUF_W + SLOT_W;

    logic [NUM_BUF-1:0] w_match, w_ready, w_req, w_alloc, w_pop, w_grant, w_rsp;
    logic [DATA_W-1:0]  w_data [NUM_BUF];
    logic [LINE_W-1:0]  w_line [NUM_BUF];
    logic [SLOT_W-1:0]  w_slot [NUM_BUF];

    logic             any_match, alloc_en, arb_any;
    logic [BUF_W-1:0] sel, victim, pick;

    always_comb begin
        any_match = 1'b0;
        sel       = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (w_match[i]) begin
                any_match = 1'b1;
                sel       = BUF_W'(i);
            end
        end
    end

    assign sb_hit   = any_match && w_ready[sel];
    assign sb_stall = any_match && !w_ready[sel];
    assign sb_data  = w_data[sel];
    assign alloc_en = acc_valid && l1_miss && !any_match;

    assign mem_req_valid = arb_any;
    assign mem_req_line  = w_line[pick];
    assign mem_req_tag   = TAG_W'({pick, w_slot[pick]});

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        assign w_alloc[i] = alloc_en && (victim == BUF_W'(i));
        assign w_pop[i]   = sb_hit && (sel == BUF_W'(i));
        assign w_grant[i] = arb_any && mem_req_ready && (pick == BUF_W'(i));
        assign w_rsp[i]   = mem_rsp_valid && (mem_rsp_tag[TAG_W-1:SLOT_W] == BUF_W'(i));

        sbp_way #(.LINE_W(LINE_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_valid  (acc_valid),
            .acc_line   (acc_line),
            .alloc      (w_alloc[i]),
            .pop        (w_pop[i]),
            .grant      (w_grant[i]),
            .rsp_valid  (w_rsp[i]),
            .rsp_slot   (mem_rsp_tag[SLOT_W-1:0]),
            .rsp_data   (mem_rsp_data),
            .head_match (w_match[i]),
            .head_ready (w_ready[i]),
            .head_data  (w_data[i]),
            .req_valid  (w_req[i]),
            .req_line   (w_line[i]),
            .req_slot   (w_slot[i])
        );
    end

    sbp_lru #(.N(NUM_BUF)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch    (alloc_en || sb_hit),
        .touch_id (alloc_en ? victim : sel),
        .victim   (victim)
    );

    sbp_arb #(.N(NUM_BUF)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (w_req),
        .adv   (arb_any && mem_req_ready),
        .any   (arb_any),
        .pick  (pick)
    );

    // R4
    hit_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_hit && sb_stall));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // R2
    no_acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!sb_hit && !sb_stall));
endmodule

// File: tb/tb_stream_prefetch.sv
module tb_stream_prefetch;
    localparam int TAG_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [15:0]       acc_line = '0;
    logic              l1_miss = 1'b0;
    logic              sb_hit, sb_stall;
    logic [31:0]       sb_data;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic [15:0]       mem_req_line;
    logic [TAG_W-1:0]  mem_req_tag;
    logic              mem_rsp_valid = 1'b0;
    logic [TAG_W-1:0]  mem_rsp_tag = '0;
    logic [31:0]       mem_rsp_data = '0;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    stream_prefetch dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .l1_miss(l1_miss), .sb_hit(sb_hit), .sb_stall(sb_stall), .sb_data(sb_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] fdat(input logic [15:0] l);
        return {l ^ 16'h5A3C, l};
    endfunction

    // memory model: accepted requests answer three cycles later, in order
    logic [TAG_W-1:0] q_tag  [64];
    logic [15:0]      q_line [64];
    int               q_due  [64];
    int               q_wr = 0, q_rd = 0, cyc = 0;
    logic [15:0]      log_line [512];
    logic [TAG_W-1:0] log_tag  [512];
    int               log_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            q_tag[q_wr % 64]  = mem_req_tag;
            q_line[q_wr % 64] = mem_req_line;
            q_due[q_wr % 64]  = cyc + 3;
            q_wr++;
            log_line[log_n % 512] = mem_req_line;
            log_tag[log_n % 512]  = mem_req_tag;
            log_n++;
        end
        if (q_rd != q_wr && q_due[q_rd % 64] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_tag   = q_tag[q_rd % 64];
            mem_rsp_data  = fdat(q_line[q_rd % 64]);
            q_rd++;
        end else begin
            mem_rsp_valid = 1'b0;
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // {line, l1_miss, expected hit}; each access is made after all fills settle
    localparam logic [17:0] VEC [13] = '{
        {16'h0100, 1'b1, 1'b0},   // R1 allocate
        {16'h0100, 1'b1, 1'b1},   // R2
        {16'h0101, 1'b1, 1'b1},   // R3 popped head advanced
        {16'h0200, 1'b1, 1'b0},   // R6 second stream
        {16'h0200, 1'b1, 1'b1},
        {16'h0102, 1'b1, 1'b1},   // R6 first stream survived
        {16'h0300, 1'b1, 1'b0},   // R6 replaces older stream
        {16'h0201, 1'b1, 1'b0},   // replaced stream misses
        {16'h0300, 1'b1, 1'b1},
        {16'h0201, 1'b1, 1'b1},
        {16'h0202, 1'b0, 1'b1},   // hit regardless of cache flag
        {16'h0500, 1'b0, 1'b0},   // R5 cache hit, no allocation
        {16'h0301, 1'b1, 1'b1}    // R5 LRU buffer was left intact
    };

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        logic got;
        logic [15:0] l1, l2;
        int alt_bad;

        repeat (3) @(negedge clk);
        check("R10 hit", 32'(sb_hit), 32'd0);
        check("R10 stall", 32'(sb_stall), 32'd0);
        check("R10 req", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 req after release", 32'(mem_req_valid), 32'd0);

        for (int v = 0; v < 13; v++) begin
            acc_valid = 1'b1;
            acc_line  = VEC[v][17:2];
            l1_miss   = VEC[v][1];
            #2;
            check($sformatf("R2 R6 vec%0d hit", v), 32'(sb_hit), 32'(VEC[v][0]));
            check($sformatf("R4 vec%0d stall", v), 32'(sb_stall), 32'd0);
            if (VEC[v][0]) check($sformatf("R2 vec%0d data", v), sb_data, fdat(VEC[v][17:2]));
            @(negedge clk);
            acc_valid = 1'b0;
            repeat (12) @(negedge clk);
        end

        // R1: request order after an allocation
        n0 = log_n;
        acc_valid = 1'b1; acc_line = 16'h0700; l1_miss = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (12) @(negedge clk);
        check("R1 count", 32'(log_n - n0), 32'd4);
        for (int k = 0; k < 4; k++)
            check("R1 line", 32'(log_line[(n0 + k) % 512]), 32'(16'h0700 + k));

        // R4: access right behind its own allocation stalls, then hits
        acc_valid = 1'b1; acc_line = 16'h0800; l1_miss = 1'b1;
        @(negedge clk);
        #2;
        check("R4 stall", 32'(sb_stall), 32'd1);
        check("R4 no hit", 32'(sb_hit), 32'd0);
        got = 1'b0;
        for (int i = 0; i < 12 && !got; i++) begin
            @(negedge clk);
            #2;
            got = sb_hit;
        end
        check("R4 hit after fill", 32'(got), 32'd1);
        check("R4 data", sb_data, fdat(16'h0800));
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (12) @(negedge clk);
        check("R3 refill line", 32'(log_line[(log_n - 1) % 512]), 32'h0804);

        // R7: third back-to-back miss reclaims a buffer with fills in flight
        acc_valid = 1'b1; l1_miss = 1'b1; acc_line = 16'h0900;
        @(negedge clk); acc_line = 16'h0A00;
        @(negedge clk); acc_line = 16'h0B00;
        @(negedge clk); acc_valid = 1'b0;
        repeat (16) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            acc_valid = 1'b1; acc_line = 16'h0B00 + 16'(k); l1_miss = 1'b1;
            #2;
            check("R7 hit", 32'(sb_hit), 32'd1);
            check("R7 data", sb_data, fdat(16'h0B00 + 16'(k)));
            @(negedge clk);
        end
        acc_valid = 1'b0;
        repeat (12) @(negedge clk);

        // R8 R9: stalled port, two buffers waiting
        mem_req_ready = 1'b0;
        acc_valid = 1'b1; l1_miss = 1'b1; acc_line = 16'h0C00;
        @(negedge clk); acc_line = 16'h0D00;
        @(negedge clk); acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        l1 = mem_req_line;
        check("R9 valid held", 32'(mem_req_valid), 32'd1);
        @(negedge clk);
        l2 = mem_req_line;
        check("R9 line held", 32'(l2), 32'(l1));
        n0 = log_n;
        mem_req_ready = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 count", 32'(log_n - n0), 32'd8);
        alt_bad = 0;
        for (int k = 0; k < 7; k++)
            if (log_tag[(n0 + k) % 512][2] == log_tag[(n0 + k + 1) % 512][2]) alt_bad++;
        check("R8 alternation", 32'(alt_bad), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule